// File: doc/BRIEF.md
# Byte-Stream Frame Synchronizer

This block watches a stream of bytes, one byte per cycle in which `byte_valid` is high. It finds fixed-length frames in that stream. Every frame opens with a marker byte, and both the marker value and the frame length come in on input ports. After reset the synchronizer hunts for the marker. Once it has one, it locks and counts bytes through the frame. It then expects the next marker exactly one frame length after the previous one.

A marker that shows up inside a frame is an alignment error. The block flags it and restarts the frame at that marker. A missing marker at the expected slot is also an error, and the block drops back to hunting; the next marker then starts a new frame, so a late marker re-aligns the stream. Two saturating counters keep running totals of markers seen and framing errors. Each byte that belongs to a frame is passed on with a start-of-frame flag, one cycle after it arrives.

Top module: `frame_sync`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block is reset. After that edge `locked`, `out_valid`, `out_sof` and `err_pulse` are 0 and both counters read 0.
- R2: While hunting, a non-marker byte leaves `out_valid`, `err_pulse` and both counters unchanged (outputs stay 0).
- R3: While hunting, a marker byte locks the block. On the next cycle `out_valid=1`, `out_sof=1`, `err_pulse=0` and `locked=1`.
- R4: While locked, a marker arriving exactly L valid bytes after the last frame start is a good frame start. It gives `out_sof=1` with `err_pulse=0`, and the error counter is unchanged. L is the effective frame length.
- R5: While locked, a non-marker byte in the expected marker slot gives `err_pulse=1` and increments the error counter. That byte is not passed on (`out_valid=0`), and the block returns to hunting (`locked=0`).
- R6: While locked, a marker before the expected slot gives `err_pulse=1` and `out_sof=1` in the same cycle, and increments the error counter. The frame count restarts from that marker, so the next good marker is expected L bytes after it.
- R7: A late marker is one that arrives after a missed slot has returned the block to hunting. It re-locks the block with `out_sof=1` and no further error.
- R8: `marker_count` increments once for every valid byte equal to `marker`, in any state.
- R9: Both counters saturate at 2^CNT_W-1 and never wrap.
- R10: A cycle with `byte_valid=0` changes no state. On the following cycle `out_valid`, `out_sof` and `err_pulse` are 0 and the counters are stable.
- R11: A `frame_len` of 0 or 1 is treated as 1, so every byte of a locked stream must be a marker.
- R12: `out_byte` carries the byte accepted on the previous valid cycle whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Qualifies `byte_in` for this cycle |
| byte_in | input | DATA_W | Incoming stream byte |
| marker | input | DATA_W | Value of the frame marker byte |
| frame_len | input | LEN_W | Frame length in bytes, marker included |
| out_valid | output | 1 | `out_byte` belongs to a frame |
| out_byte | output | DATA_W | Registered copy of the accepted byte |
| out_sof | output | 1 | `out_byte` is a frame start |
| err_pulse | output | 1 | Framing error on the previous valid byte |
| locked | output | 1 | Block is aligned to a frame |
| marker_count | output | CNT_W | Saturating count of marker bytes |
| error_count | output | CNT_W | Saturating count of framing errors |

## Verification
An early marker triggers the error report and the start of a new frame in the same cycle. It also bumps both counters in that cycle. The bench provokes this by placing markers at offsets inside frames of several lengths. It also sends runs of back-to-back markers with long frames, which drives both counters into saturation together. A behavioural reference model tracks lock state and byte position with plain integers. Every output is compared against it on each clock, and directed checks confirm that the error and start-of-frame flags coincide while the error count advances by exactly one.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_RECV  = 2'd2
  } fs_state_t;
endpackage

// File: rtl/fs_satcnt.sv
module fs_satcnt #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (inc && q != MAXV)
      q <= q + 1'b1;
  end

  // R9: once full, the count holds
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (q == MAXV) |=> (q == MAXV));
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DATA_W-1:0] marker,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              take,
  output logic              sof,
  output logic              err,
  output logic              hit,
  output fs_state_t         state
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  fs_state_t        nxt;
  logic [LEN_W-1:0] pos, pos_n, leff;

  always_comb begin
    hit   = (byte_in == marker);
    leff  = (frame_len < LEN_W'(2)) ? ONE : frame_len;
    nxt   = state;
    pos_n = pos;
    take  = 1'b0;
    sof   = 1'b0;
    err   = 1'b0;
    if (valid) begin
      unique case (state)
        ST_HUNT: begin
          if (hit) begin
            sof   = 1'b1;
            take  = 1'b1;
            nxt   = ST_START;
            pos_n = ONE;
          end
        end
        default: begin
          if (pos >= leff) begin
            if (hit) begin
              sof   = 1'b1;
              take  = 1'b1;
              nxt   = ST_RECV;
              pos_n = ONE;
            end else begin
              err   = 1'b1;
              nxt   = ST_HUNT;
              pos_n = '0;
            end
          end else if (hit) begin
            err   = 1'b1;
            sof   = 1'b1;
            take  = 1'b1;
            nxt   = ST_START;
            pos_n = ONE;
          end else begin
            take  = 1'b1;
            pos_n = pos + ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
      pos   <= '0;
    end else begin
      state <= nxt;
      pos   <= pos_n;
    end
  end

  // R5: a slot miss without a marker drops lock
  a_r5_miss_to_hunt: assert property (@(posedge clk) disable iff (rst)
    (err && !sof) |=> (state == ST_HUNT));
  // R4: when locked, position is at least one byte into a frame
  a_r4_pos_live: assert property (@(posedge clk) disable iff (rst)
    (state != ST_HUNT) |-> (pos != '0));
  // R2: hunting never reports an error
  a_r2_hunt_no_err: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT) |-> !err);
endmodule

// File: rtl/frame_sync.sv
module frame_sync
  import fs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DATA_W-1:0] marker,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_sof,
  output logic              err_pulse,
  output logic              locked,
  output logic [CNT_W-1:0]  marker_count,
  output logic [CNT_W-1:0]  error_count
);
  localparam int NCNT = 2;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic      take, sof, err, hit;
  fs_state_t state;
  logic [NCNT-1:0]  cnt_inc;
  logic [CNT_W-1:0] cnt_q [NCNT];

  fs_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .valid(byte_valid), .byte_in(byte_in),
    .marker(marker), .frame_len(frame_len),
    .take(take), .sof(sof), .err(err), .hit(hit), .state(state)
  );

  assign cnt_inc[0] = byte_valid && hit;
  assign cnt_inc[1] = err;

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    fs_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(cnt_inc[gi]), .q(cnt_q[gi])
    );
  end

  assign marker_count = cnt_q[0];
  assign error_count  = cnt_q[1];
  assign locked       = (state != ST_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      err_pulse <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= take;
      out_sof   <= sof;
      err_pulse <= err;
      if (byte_valid)
        out_byte <= byte_in;
    end
  end

  // R10: an idle cycle produces no output activity
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_valid) |-> (!out_valid && !err_pulse && !out_sof));
  // R3: a frame start is always a passed-on byte
  a_r3_sof_valid: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  // R5: every error pulse is counted unless the counter is full
  a_r5_err_counted: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (error_count != $past(error_count) || error_count == CMAX));
  // R8: the marker total moves by at most one per cycle
  a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
    (marker_count - $past(marker_count)) <= CNT_W'(1));
endmodule

// File: tb/tb_frame_sync.sv
module tb_frame_sync;
  localparam int DW = 8, LW = 8, CW = 11;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst = 1, byte_valid = 0;
  logic [DW-1:0] byte_in = 0, marker = 8'hA5;
  logic [LW-1:0] frame_len = 8'd4;
  logic out_valid, out_sof, err_pulse, locked;
  logic [DW-1:0] out_byte;
  logic [CW-1:0] marker_count, error_count;

  int total = 0, bad = 0, cycles = 0;
  bit cmp_on = 0, done = 0;

  int m_locked, m_pos, m_mk, m_er, m_len;
  bit m_hit;
  bit e_valid, e_sof, e_err;
  logic [DW-1:0] e_byte;

  always #10 clk = ~clk;

  frame_sync #(.DATA_W(DW), .LEN_W(LW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
    .marker(marker), .frame_len(frame_len), .out_valid(out_valid),
    .out_byte(out_byte), .out_sof(out_sof), .err_pulse(err_pulse),
    .locked(locked), .marker_count(marker_count), .error_count(error_count)
  );

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_locked = 0; m_pos = 0; m_mk = 0; m_er = 0;
      e_valid = 0; e_sof = 0; e_err = 0; e_byte = 0;
    end else begin
      e_valid = 0; e_sof = 0; e_err = 0;
      if (byte_valid) begin
        m_len = (frame_len < 2) ? 1 : int'(frame_len);
        m_hit = (byte_in == marker);
        e_byte = byte_in;
        if (m_hit && m_mk < CMAX) m_mk++;
        if (!m_locked) begin
          if (m_hit) begin m_locked = 1; m_pos = 1; e_valid = 1; e_sof = 1; end
        end else if (m_pos >= m_len) begin
          if (m_hit) begin m_pos = 1; e_valid = 1; e_sof = 1; end
          else begin e_err = 1; m_locked = 0; m_pos = 0; end
        end else if (m_hit) begin
          e_err = 1; e_sof = 1; e_valid = 1; m_pos = 1;
        end else begin
          e_valid = 1; m_pos++;
        end
        if (e_err && m_er < CMAX) m_er++;
      end
    end
  end

  // per-cycle comparison against the model (R12 covers out_byte)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("model out_valid", out_valid, e_valid);
      check("model out_sof", out_sof, e_sof);
      check("model err_pulse", err_pulse, e_err);
      check("model locked", locked, m_locked);
      check("R8 model marker_count", marker_count, m_mk);
      check("model error_count", error_count, m_er);
      if (e_valid) check("R12 model out_byte", out_byte, e_byte);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      finish_run();
    end
  end

  task automatic step(bit v, logic [DW-1:0] b);
    byte_valid = v; byte_in = b;
    @(negedge clk);
  endtask

  initial begin
    int ec, mc;
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R1 reset state
    check("R1 locked", locked, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 counts", {marker_count, error_count}, 0);
    // R2 noise in hunt
    step(1, 8'h11); step(1, 8'h22); step(1, 8'h33);
    check("R2 no output", out_valid, 0);
    check("R2 no count", marker_count + error_count, 0);
    // R3 lock on marker
    step(1, 8'hA5);
    check("R3 sof", out_sof, 1);
    check("R3 locked", locked, 1);
    check("R8 first marker", marker_count, 1);
    // R4 good frame, R12 data passthrough
    step(1, 8'h01);
    check("R12 out_byte", out_byte, 8'h01);
    step(1, 8'h02); step(1, 8'h03); step(1, 8'hA5);
    check("R4 sof", out_sof, 1);
    check("R4 no err", err_pulse, 0);
    // R5 slot miss
    step(1, 8'h04); step(1, 8'h05); step(1, 8'h06);
    ec = error_count;
    step(1, 8'h00);
    check("R5 err", err_pulse, 1);
    check("R5 count", error_count, ec + 1);
    check("R5 dropped byte", out_valid, 0);
    check("R5 unlocked", locked, 0);
    // R7 late marker
    step(1, 8'h07); step(1, 8'hA5);
    check("R7 sof", out_sof, 1);
    check("R7 no extra err", error_count, ec + 1);
    // R6 early marker
    step(1, 8'h08); step(1, 8'hA5);
    check("R6 err and sof", {err_pulse, out_sof}, 2'b11);
    check("R6 count", error_count, ec + 2);
    step(1, 8'h09); step(1, 8'h0A); step(1, 8'h0B); step(1, 8'hA5);
    check("R6 restart sof", out_sof, 1);
    check("R6 restart no err", err_pulse, 0);
    // R10 idle cycle
    mc = marker_count; ec = error_count;
    step(0, 8'hA5);
    check("R10 quiet", {out_valid, out_sof, err_pulse}, 0);
    check("R10 stable", {marker_count, error_count}, {mc[CW-1:0], ec[CW-1:0]});
    check("R10 lock kept", locked, 1);
    // R11 lengths 0 and 1
    for (int k = 0; k < 2; k++) begin
      frame_len = LW'(k);
      step(1, 8'hA5);
      check("R11 sof", {out_sof, err_pulse}, 2'b10);
      step(1, 8'hA5);
      check("R11 every byte marker", {out_sof, err_pulse}, 2'b10);
      ec = error_count;
      step(1, 8'h55);
      check("R11 non-marker err", err_pulse, 1);
      check("R11 count", error_count, ec + 1);
    end
    // R6 early marker with another length and marker value
    marker = 8'h3C; frame_len = 8'd6;
    step(1, 8'h3C); step(1, 8'h01); step(1, 8'h02); step(1, 8'h3C);
    check("R6 early len6", {err_pulse, out_sof}, 2'b11);
    // R9 saturation via back-to-back early markers
    frame_len = 8'd200;
    for (int i = 0; i < 2100; i++) step(1, 8'h3C);
    check("R9 marker sat", marker_count, CMAX);
    check("R9 error sat", error_count, CMAX);
    step(1, 8'h3C);
    check("R9 no wrap", error_count, CMAX);
    step(0, 8'h00);
    finish_run();
  end
endmodule